// File: doc/BRIEF.md
# Four-Operand Vector Crypto Unit

This unit decodes one class of 32-bit instruction words whose operands are three 128-bit vector source registers and one 128-bit destination, and executes them against a private 32-entry by 128-bit register file. Three operations are supported:

- a three-input exclusive OR;
- an exclusive OR with a bit-cleared term;
- a hash round step. This step works only on the top 32-bit lane, using rotates and modular adds, and it writes zeros to the rest of the destination.

Every valid word that belongs to the class ends in exactly one of three outcomes:

- an undefined-instruction flag;
- an access-trap flag;
- a completed write.

Each outcome is signalled one cycle after the strobe. Words outside the class are silently ignored, so the unit can sit beside other decoders on a shared instruction bus. A load port fills the register file. A combinational read port brings any register out.

Top module: `vcrypt4_unit`

## Requirements
- R1: After reset, every register reads zero and the three outcome flags are low.
- R2: A word belongs to the class only when bits [31:23] equal 9'b110011100 and bit 15 is 0. Any other word with the strobe high raises no flag and writes no register.
- R3: Field positions are fixed. Bits [22:21] hold the operation code, [20:16] the second source (M), [14:10] the third source (A), [9:5] the first source (N) and [4:0] the destination (D).
- R4: Code 0 writes N ^ M ^ A over all 128 bits.
- R5: Code 1 writes N ^ (M & ~A) over all 128 bits.
- R6: Code 2 takes bits [127:96] of N, M and A, and forms ror(ror(N,20) + M + A, 25) modulo 2^32. It writes that value to bits [127:96] of D and zero to bits [95:0].
- R7: Code 3 raises the undefined flag and writes nothing, whatever the enables are.
- R8: Codes 0 and 1 need `xor_feat_en` high, and code 2 needs `hash_feat_en` high. Without its enable an instruction raises the undefined flag and writes nothing.
- R9: When the feature check passes but `simd_access_en` is low, the trap flag is raised and nothing is written.
- R10: Each valid word in the class produces exactly one of `wr_done`, `undef_flag` or `trap_flag`. That output is a single-cycle pulse on the clock edge that samples the strobe.
- R11: The destination may be the same register as any source. The result is still computed from the values held before the write.
- R12: The load port writes `ld_data` into register `ld_idx` on the clock edge. If an executed write targets the same register on the same edge, the executed write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| xor_feat_en | input | 1 | Enables codes 0 and 1 |
| hash_feat_en | input | 1 | Enables code 2 |
| simd_access_en | input | 1 | Vector register access permitted |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 5 | Register to load |
| ld_data | input | 128 | Load value |
| rd_idx | input | 5 | Register to observe |
| rd_data | output | 128 | Contents of register `rd_idx` |
| wr_done | output | 1 | Result written this cycle |
| undef_flag | output | 1 | Undefined instruction |
| trap_flag | output | 1 | Access trap |

## Verification
The bench drives every operation code under every combination of enables that matters for checking priority. A design that tested access before feature support, or that let code 3 trap instead of becoming undefined, would raise the wrong flag. The bench uses destinations that alias the sources, which exposes a result computed from partly updated registers. It also sends words with bit 15 set or a changed prefix, where a loose decoder would write or flag when it should stay silent. It checks the zeroed low lanes of the hash step, which a design that merged only the top lane would leave stale. Finally, it makes a load collide with an executed write on the same register to confirm that the executed write wins.

// File: rtl/vcrypt4_unit.sv
module vcrypt4_unit #(
  parameter int VW = 128,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    insn_valid,
  input  logic [31:0]             insn,
  input  logic                    xor_feat_en,
  input  logic                    hash_feat_en,
  input  logic                    simd_access_en,
  input  logic                    ld_en,
  input  logic [$clog2(NREG)-1:0] ld_idx,
  input  logic [VW-1:0]           ld_data,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [VW-1:0]           rd_data,
  output logic                    wr_done,
  output logic                    undef_flag,
  output logic                    trap_flag
);
  localparam int IW = $clog2(NREG);
  localparam int HW = VW / 2;
  localparam int LW = 32;
  localparam logic [8:0] CLASS_TAG = 9'b110011100;

  logic [VW-1:0] rf [NREG];

  logic          in_class;
  logic [1:0]    opc;
  logic [IW-1:0] f_d, f_n, f_m, f_a;
  logic [VW-1:0] src_n, src_m, src_a;
  logic          feat_ok;
  logic [VW-1:0] result;
  logic [LW-1:0] lane_n, lane_m, lane_a, rot_n, lane_sum, lane_out;

  assign in_class = (insn[31:23] == CLASS_TAG) && !insn[15];
  assign opc = insn[22:21];
  assign f_m = insn[20:16];
  assign f_a = insn[14:10];
  assign f_n = insn[9:5];
  assign f_d = insn[4:0];

  assign src_n = rf[f_n];
  assign src_m = rf[f_m];
  assign src_a = rf[f_a];

  assign lane_n = src_n[VW-1 -: LW];
  assign lane_m = src_m[VW-1 -: LW];
  assign lane_a = src_a[VW-1 -: LW];
  assign rot_n = {lane_n[19:0], lane_n[LW-1:20]};
  assign lane_sum = rot_n + lane_m + lane_a;
  assign lane_out = {lane_sum[24:0], lane_sum[LW-1:25]};

  always_comb begin
    case (opc)
      2'd0:    feat_ok = xor_feat_en;
      2'd1:    feat_ok = xor_feat_en;
      2'd2:    feat_ok = hash_feat_en;
      default: feat_ok = 1'b0;
    endcase
  end

  always_comb begin
    result = '0;
    for (int h = 0; h < 2; h++) begin
      case (opc)
        2'd0:    result[h*HW +: HW] = src_n[h*HW +: HW] ^ src_m[h*HW +: HW] ^ src_a[h*HW +: HW];
        2'd1:    result[h*HW +: HW] = src_n[h*HW +: HW] ^ (src_m[h*HW +: HW] & ~src_a[h*HW +: HW]);
        default: result[h*HW +: HW] = '0;
      endcase
    end
    if (opc == 2'd2) result[VW-1 -: LW] = lane_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      wr_done    <= 1'b0;
      undef_flag <= 1'b0;
      trap_flag  <= 1'b0;
    end else begin
      wr_done    <= 1'b0;
      undef_flag <= 1'b0;
      trap_flag  <= 1'b0;
      if (ld_en) rf[ld_idx] <= ld_data;
      if (insn_valid && in_class) begin
        if (!feat_ok) undef_flag <= 1'b1;
        else if (!simd_access_en) trap_flag <= 1'b1;
        else begin
          rf[f_d] <= result;
          wr_done <= 1'b1;
        end
      end
    end
  end

  assign rd_data = rf[rd_idx];

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_done, undef_flag, trap_flag}));

  // R10
  outcome_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done || undef_flag || trap_flag) |-> $past(insn_valid));

  // R2
  foreign_word_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !in_class) |=> !(wr_done || undef_flag || trap_flag));

  // R7
  code3_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && in_class && opc == 2'd3) |=> undef_flag);

  // R9
  access_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && in_class && feat_ok && !simd_access_en) |=> (trap_flag && !wr_done));

  // R6
  hash_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && in_class && opc == 2'd2 && feat_ok && simd_access_en)
      |=> (rf[$past(f_d)][VW-LW-1:0] == '0));
endmodule

// File: tb/tb_vcrypt4_unit.sv
`timescale 1ns/100ps
module tb_vcrypt4_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic         xor_feat_en = 1'b0, hash_feat_en = 1'b0, simd_access_en = 1'b0;
  logic         ld_en = 1'b0;
  logic [4:0]   ld_idx = '0, rd_idx = '0;
  logic [127:0] ld_data = '0;
  logic [127:0] rd_data;
  logic         wr_done, undef_flag, trap_flag;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [127:0] model [32];

  always #2.5 clk = ~clk;

  vcrypt4_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .xor_feat_en(xor_feat_en), .hash_feat_en(hash_feat_en), .simd_access_en(simd_access_en),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_done(wr_done), .undef_flag(undef_flag), .trap_flag(trap_flag)
  );

  // op[7:6] xor_en[5] hash_en[4] access[3] expect[1:0]: 0 none, 1 write, 2 undef, 3 trap
  localparam logic [7:0] VEC [12] = '{
    {2'd0, 3'b101, 1'b0, 2'd1},
    {2'd1, 3'b101, 1'b0, 2'd1},
    {2'd2, 3'b011, 1'b0, 2'd1},
    {2'd3, 3'b111, 1'b0, 2'd2},
    {2'd0, 3'b011, 1'b0, 2'd2},
    {2'd1, 3'b001, 1'b0, 2'd2},
    {2'd2, 3'b101, 1'b0, 2'd2},
    {2'd1, 3'b110, 1'b0, 2'd3},
    {2'd2, 3'b010, 1'b0, 2'd3},
    {2'd3, 3'b110, 1'b0, 2'd2},
    {2'd0, 3'b000, 1'b0, 2'd2},
    {2'd2, 3'b111, 1'b0, 2'd1}
  };

  function automatic logic [31:0] rr(input logic [31:0] x, input int s);
    return (x >> s) | (x << (32 - s));
  endfunction

  function automatic logic [127:0] ref_op(input logic [1:0] op, input logic [127:0] n, m, a);
    logic [31:0] t;
    case (op)
      2'd0: return n ^ m ^ a;
      2'd1: return n ^ (m & ~a);
      default: begin
        t = rr(rr(n[127:96], 20) + m[127:96] + a[127:96], 25);
        return {t, 96'd0};
      end
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] d, n, m, a);
    return {9'b110011100, op, m, 1'b0, a, n, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    bit ok = 1;
    logic [127:0] a = '0, e = '0;
    for (int i = 0; i < 32; i++) begin
      rd_idx = 5'(i);
      #0.1;
      if (rd_data !== model[i] && ok) begin ok = 0; a = rd_data; e = model[i]; end
    end
    chk(ok, req, a, e);
  endtask

  task automatic run(input logic [31:0] w, input logic fx, fh, sa, input logic [1:0] expc,
                     input bit ld, input logic [4:0] li, input logic [127:0] ldv, input string req);
    logic [1:0] op = w[22:21];
    logic [127:0] r = ref_op(op, model[w[9:5]], model[w[20:16]], model[w[14:10]]);
    @(negedge clk);
    insn = w; insn_valid = 1'b1;
    xor_feat_en = fx; hash_feat_en = fh; simd_access_en = sa;
    ld_en = ld; ld_idx = li; ld_data = ldv;
    @(posedge clk); #1;
    insn_valid = 1'b0; ld_en = 1'b0;
    if (ld) model[li] = ldv;
    if (expc == 2'd1) model[w[4:0]] = r;
    chk({wr_done, undef_flag, trap_flag} == {expc == 2'd1, expc == 2'd2, expc == 2'd3},
        req, {125'd0, wr_done, undef_flag, trap_flag},
        {125'd0, expc == 2'd1, expc == 2'd2, expc == 2'd3});
    check_regs(req);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] d, n, m, a;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk({wr_done, undef_flag, trap_flag} == 3'b000, "R1 flags",
        {125'd0, wr_done, undef_flag, trap_flag}, '0);
    check_regs("R1 regs zero");
    @(negedge clk); rst_n = 1'b1;

    // R12 preload
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 5'(i);
      ld_data = {$urandom, $urandom, $urandom, $urandom};
      model[i] = ld_data;
    end
    @(negedge clk); ld_en = 1'b0;
    check_regs("R12 preload");

    // R3 R4 R5 R6 R7 R8 R9: table walk
    for (int k = 0; k < 12; k++) begin
      d = 5'($urandom); n = 5'($urandom); m = 5'($urandom); a = 5'($urandom);
      run(mk(VEC[k][7:6], d, n, m, a), VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][1:0],
          0, '0, '0, $sformatf("R4/R5/R6/R7/R8/R9 vec %0d", k));
    end

    // R3 distinct fields, fixed picks
    run(mk(2'd1, 5'd3, 5'd7, 5'd12, 5'd30), 1, 1, 1, 2'd1, 0, '0, '0, "R3 fields op1");
    run(mk(2'd2, 5'd31, 5'd0, 5'd17, 5'd9), 1, 1, 1, 2'd1, 0, '0, '0, "R6 hash lanes");

    // R10 pulse drops
    @(negedge clk); @(posedge clk); #1;
    chk({wr_done, undef_flag, trap_flag} == 3'b000, "R10 single pulse",
        {125'd0, wr_done, undef_flag, trap_flag}, '0);

    // R11 aliasing
    run(mk(2'd0, 5'd5, 5'd5, 5'd5, 5'd5), 1, 0, 1, 2'd1, 0, '0, '0, "R11 all alias");
    run(mk(2'd1, 5'd6, 5'd6, 5'd8, 5'd9), 1, 0, 1, 2'd1, 0, '0, '0, "R11 rd=rn");
    run(mk(2'd2, 5'd10, 5'd11, 5'd10, 5'd10), 0, 1, 1, 2'd1, 0, '0, '0, "R11 hash alias");

    // R2 foreign words
    run(mk(2'd0, 5'd2, 5'd3, 5'd4, 5'd5) | 32'h0000_8000, 1, 1, 1, 2'd0, 0, '0, '0, "R2 bit15");
    run(mk(2'd3, 5'd2, 5'd3, 5'd4, 5'd5) ^ 32'h0080_0000, 1, 1, 1, 2'd0, 0, '0, '0, "R2 prefix");
    run(mk(2'd1, 5'd2, 5'd3, 5'd4, 5'd5) ^ 32'h8000_0000, 1, 1, 1, 2'd0, 0, '0, '0, "R2 top bit");

    // R12 collision: exec wins; and load to other reg alongside
    run(mk(2'd0, 5'd20, 5'd1, 5'd2, 5'd3), 1, 0, 1, 2'd1, 1, 5'd20, {4{32'hdead_beef}}, "R12 collide");
    run(mk(2'd0, 5'd21, 5'd1, 5'd2, 5'd3), 1, 0, 1, 2'd1, 1, 5'd22, {4{32'h1234_5678}}, "R12 parallel");
    // R9 trapped word with load to its destination: load alone lands
    run(mk(2'd1, 5'd23, 5'd1, 5'd2, 5'd3), 1, 0, 0, 2'd3, 1, 5'd23, {4{32'h0f0f_0f0f}}, "R9 trap no write");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule